// File: doc/BRIEF.md
# Four-Channel PWM Command and Status Register Front End

This block is the software-visible register layer that sits in front of a set of PWM channel engines. It decodes a simple memory-mapped bus made of an address, write data, a write strobe, a read strobe and registered read data. It handles four global registers and forwards every other mapped access to the channel engines. The waveform logic is not part of this block. Each engine shows up here only through a run request (`ch_run`) and a one-cycle pulse (`ch_pstart`) marking each period start.

The global registers are as follows:
- An enable command register, where writing one-bits starts channels.
- A disable command register, where writing one-bits stops channels.
- A status register showing which channels are still running.
- A period-event register that collects period-start pulses and is emptied by a read.

A disable does not take effect at once. The channel finishes its current period, and only at the next period-start pulse do its run request and status bit drop. Software can poll the status register to learn when the stop is complete.

Each channel has its own state machine with three states:
- `ST_IDLE`: the channel is stopped.
- `ST_RUN`: the channel is running.
- `ST_DRAIN`: a stop has been requested and the channel is finishing its current period.

The transitions between them are:
- START: `ST_IDLE` to `ST_RUN` on an enable bit.
- STOP_REQ: `ST_RUN` to `ST_DRAIN` on a disable bit.
- RESUME: `ST_DRAIN` to `ST_RUN` on an enable bit.
- HALT: `ST_DRAIN` to `ST_IDLE` on a period-start pulse.

Every other combination leaves the state unchanged. The run request and the status bit are both high in `ST_RUN` and in `ST_DRAIN`.

Top module: `pwm_ctl_regs`

## Requirements
- R1: A write to offset 0x04 moves every idle channel n whose data bit n is 1 to running. Its `ch_run` bit and status bit read 1 from the cycle after the write.
- R2: A write to offset 0x08 with bit n set puts a running channel n into draining. Its `ch_run` bit and status bit stay 1 until a `ch_pstart` pulse on that channel, and both drop in the cycle after that pulse.
- R3: Zero bits in either command write have no effect. A disable bit on an idle channel and an enable bit on a running channel also have no effect.
- R4: An enable bit for a draining channel returns it to running, even when a `ch_pstart` pulse for that channel arrives in the same cycle.
- R5: A read of offset 0x0C returns the running/draining flags in bits [3:0] (bit n is channel n), with all other bits 0.
- R6: Each `ch_pstart` pulse on channel n sets bit n of the event register at offset 0x1C. A read returns the collected bits in [3:0] and empties the register.
- R7: A `ch_pstart` pulse in the same cycle as an event-register read is absent from that read's value and is returned by the next read.
- R8: An access to 0x200 + n*0x20 + k at a mapped k drives `ch_wr[n]` or `ch_rd[n]` high in that same cycle, with `ch_off` = k. A read returns channel n's slice of `ch_rdata`.
- R9: With `SEP_UPD`=1 the mapped window offsets are 0x00, 0x04, 0x08, 0x0C and 0x10. With `SEP_UPD`=0 offset 0x0C is unmapped and the other four remain mapped.
- R10: Reads of unmapped addresses return 0. Writes to them raise no channel strobe and change no state. Unmapped addresses include channel windows at or beyond index 4 and misaligned offsets.
- R11: Read data appears on `bus_rdata` in the cycle after the read strobe and holds until the next read.
- R12: After reset, `ch_run`, the status and event registers and `bus_rdata` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| ch_run | output | NCH | Per-channel run request |
| ch_pstart | input | NCH | Per-channel period-start pulse |
| ch_wr | output | NCH | Per-channel window write strobe |
| ch_rd | output | NCH | Per-channel window read strobe |
| ch_off | output | 5 | Offset inside the channel window |
| ch_rdata | input | NCH*DATA_W | Packed per-channel read data, channel n at bits n*DATA_W |

## Verification
The command registers are exercised with several kinds of write:
- Multi-bit enables.
- All-zero writes.
- A disable aimed at an idle channel, which separates a true set/clear decode from a plain bit copy.

The drain behaviour is tested twice. One test polls the status register before and after the stopping pulse, to show that the stop waits for a period boundary. The other sends an enable and a pulse in the same cycle, to show which of the two wins.

The event register is read back to back, and once with a pulse landing on the read itself. This separates a clear that drops the coincident pulse from one that keeps it.

Window accesses go to two layout variants in parallel. The bench also probes unmapped, out-of-range and misaligned addresses, so the decoder's mapping is pinned down exactly.

// File: rtl/pwm_regs_pkg.sv
package pwm_regs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2
    } chan_state_e;

    localparam int unsigned OFS_ENABLE  = 32'h004;
    localparam int unsigned OFS_DISABLE = 32'h008;
    localparam int unsigned OFS_STATUS  = 32'h00C;
    localparam int unsigned OFS_EVENT   = 32'h01C;
    localparam int unsigned WIN_BASE    = 32'h200;
    localparam int unsigned WIN_LG      = 5;

    // R9: window offsets that reach a channel engine for a given layout
    function automatic logic win_off_ok(input logic [WIN_LG-1:0] off, input logic sep);
        case (off)
            5'h00, 5'h04, 5'h08, 5'h10: return 1'b1;
            5'h0C:                      return sep;
            default:                    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pwm_addr_dec.sv
module pwm_addr_dec
    import pwm_regs_pkg::*;
#(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned NCH     = 4,
    parameter bit          SEP_UPD = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit_en,
    output logic              hit_dis,
    output logic              hit_stat,
    output logic              hit_evt,
    output logic [NCH-1:0]    hit_ch,
    output logic [WIN_LG-1:0] win_off
);
    localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(OFS_ENABLE);
    localparam logic [ADDR_W-1:0] A_DIS  = ADDR_W'(OFS_DISABLE);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_EVT  = ADDR_W'(OFS_EVENT);

    logic off_ok;

    assign hit_en   = (addr == A_EN);
    assign hit_dis  = (addr == A_DIS);
    assign hit_stat = (addr == A_STAT);
    assign hit_evt  = (addr == A_EVT);
    assign win_off  = addr[WIN_LG-1:0];
    assign off_ok   = win_off_ok(win_off, SEP_UPD);

    generate
        for (genvar n = 0; n < NCH; n++) begin : g_win
            localparam logic [ADDR_W-1:0] BASE_N = ADDR_W'(WIN_BASE + n * (1 << WIN_LG));
            assign hit_ch[n] = off_ok && (addr[ADDR_W-1:WIN_LG] == BASE_N[ADDR_W-1:WIN_LG]);
        end
    endgenerate

endmodule

// File: rtl/pwm_ch_fsm.sv
module pwm_ch_fsm
    import pwm_regs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_cmd,
    input  logic dis_cmd,
    input  logic pstart,
    output logic busy
);
    chan_state_e state_q, state_d;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (en_cmd)  state_d = ST_RUN;      // START
            ST_RUN:   if (dis_cmd) state_d = ST_DRAIN;    // STOP_REQ
            ST_DRAIN: begin
                if (en_cmd)      state_d = ST_RUN;        // RESUME (wins, R4)
                else if (pstart) state_d = ST_IDLE;       // HALT
            end
            default:             state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_RUN, ST_DRAIN: busy = 1'b1;
            default:          busy = 1'b0;
        endcase
    end

    a_r1_start: assert property (@(posedge clk) disable iff (!rst_n)
        (en_cmd && state_q == ST_IDLE) |=> busy);
    a_r2_stop_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(pstart));
    a_r3_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !en_cmd) |=> !busy);
    a_r4_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (en_cmd && state_q == ST_DRAIN) |=> (state_q == ST_RUN));

endmodule

// File: rtl/pwm_evt_reg.sv
module pwm_evt_reg #(
    parameter int unsigned NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] pulse,
    input  logic           clr,
    output logic [NCH-1:0] ev_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= (clr ? '0 : ev_q) | pulse;
    end

    a_r7_no_lost_event: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse != '0) |=> ((ev_q & $past(pulse)) == $past(pulse)));
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && pulse == '0) |=> (ev_q == '0));

endmodule

// File: rtl/pwm_ctl_regs.sv
module pwm_ctl_regs
    import pwm_regs_pkg::*;
#(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned NCH     = 4,
    parameter bit          SEP_UPD = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic [NCH-1:0]        ch_run,
    input  logic [NCH-1:0]        ch_pstart,
    output logic [NCH-1:0]        ch_wr,
    output logic [NCH-1:0]        ch_rd,
    output logic [WIN_LG-1:0]     ch_off,
    input  logic [NCH*DATA_W-1:0] ch_rdata
);
    logic           hit_en, hit_dis, hit_stat, hit_evt, any_hit;
    logic [NCH-1:0] hit_ch, en_vec, dis_vec, busy, ev_q;
    logic [DATA_W-1:0] rd_mux, rdata_q;

    pwm_addr_dec #(.ADDR_W(ADDR_W), .NCH(NCH), .SEP_UPD(SEP_UPD)) u_dec (
        .addr(bus_addr), .hit_en(hit_en), .hit_dis(hit_dis), .hit_stat(hit_stat),
        .hit_evt(hit_evt), .hit_ch(hit_ch), .win_off(ch_off)
    );

    assign any_hit = hit_en | hit_dis | hit_stat | hit_evt | (|hit_ch);
    assign en_vec  = (bus_wr && hit_en)  ? bus_wdata[NCH-1:0] : '0;
    assign dis_vec = (bus_wr && hit_dis) ? bus_wdata[NCH-1:0] : '0;
    assign ch_wr   = bus_wr ? hit_ch : '0;
    assign ch_rd   = bus_rd ? hit_ch : '0;

    generate
        for (genvar n = 0; n < NCH; n++) begin : g_ch
            pwm_ch_fsm u_fsm (
                .clk(clk), .rst_n(rst_n), .en_cmd(en_vec[n]), .dis_cmd(dis_vec[n]),
                .pstart(ch_pstart[n]), .busy(busy[n])
            );
        end
    endgenerate

    assign ch_run = busy;

    pwm_evt_reg #(.NCH(NCH)) u_evt (
        .clk(clk), .rst_n(rst_n), .pulse(ch_pstart),
        .clr(bus_rd && hit_evt), .ev_q(ev_q)
    );

    always_comb begin
        rd_mux = '0;
        if (hit_stat) rd_mux[NCH-1:0] = busy;
        if (hit_evt)  rd_mux[NCH-1:0] = ev_q;
        for (int n = 0; n < NCH; n++) begin
            if (hit_ch[n]) rd_mux = rd_mux | ch_rdata[n*DATA_W +: DATA_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;

    a_r10_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !any_hit) |=> (bus_rdata == '0));
    a_r11_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
    a_r8_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit_en, hit_dis, hit_stat, hit_evt, hit_ch}));
    a_r10_no_stray_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !any_hit |-> (ch_wr == '0 && ch_rd == '0));

endmodule

// File: tb/pwm_ctl_regs_tb.sv
module pwm_ctl_regs_tb_top;
    localparam int AW = 12;
    localparam int DW = 32;
    localparam int NC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic wr = 1'b0, rd = 1'b0;
    logic [NC-1:0] pstart = '0;

    logic [DW-1:0] rdata0, rdata1;
    logic [NC-1:0] run0, run1, cwr0, cwr1, crd0, crd1;
    logic [4:0] off0, off1;
    logic [NC*DW-1:0] crdata0, crdata1;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    generate
        for (genvar n = 0; n < NC; n++) begin : g_model
            assign crdata0[n*DW +: DW] = {8'hA5, 8'(n), 11'd0, off0};
            assign crdata1[n*DW +: DW] = {8'hA5, 8'(n), 11'd0, off1};
        end
    endgenerate

    pwm_ctl_regs #(.ADDR_W(AW), .DATA_W(DW), .NCH(NC), .SEP_UPD(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata), .bus_wr(wr),
        .bus_rd(rd), .bus_rdata(rdata0), .ch_run(run0), .ch_pstart(pstart),
        .ch_wr(cwr0), .ch_rd(crd0), .ch_off(off0), .ch_rdata(crdata0)
    );

    pwm_ctl_regs #(.ADDR_W(AW), .DATA_W(DW), .NCH(NC), .SEP_UPD(1'b0)) dut_shared_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata), .bus_wr(wr),
        .bus_rd(rd), .bus_rdata(rdata1), .ch_run(run1), .ch_pstart(pstart),
        .ch_wr(cwr1), .ch_rd(crd1), .ch_off(off1), .ch_rdata(crdata1)
    );

    typedef struct {
        logic [DW-1:0] exp0;
        logic [DW-1:0] exp1;
        bit            chk1;
        string         tag;
    } rd_item_t;

    rd_item_t sb_q[$];
    logic rd_seen = 1'b0;

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    always @(posedge clk) rd_seen <= rd;

    // monitor: pops one expected item per completed read
    always @(negedge clk) begin
        if (rd_seen) begin
            if (sb_q.size() == 0) begin
                check("R11 unexpected read result", rdata0, 32'hx);
            end else begin
                rd_item_t it;
                it = sb_q.pop_front();
                check({it.tag, " (sep layout)"}, rdata0, it.exp0);
                if (it.chk1) check({it.tag, " (shared layout)"}, rdata1, it.exp1);
            end
        end
    end

    task automatic cyc(input bit w, input bit r, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic [NC-1:0] p);
        wr = w; rd = r; addr = a; wdata = d; pstart = p;
        @(negedge clk);
        wr = 1'b0; rd = 1'b0; pstart = '0;
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        cyc(1'b1, 1'b0, a, d, '0);
    endtask

    task automatic bus_read(input logic [AW-1:0] a, input logic [DW-1:0] e0,
                            input logic [DW-1:0] e1, input bit c1, input string tag,
                            input logic [NC-1:0] p = '0);
        rd_item_t it;
        it.exp0 = e0; it.exp1 = e1; it.chk1 = c1; it.tag = tag;
        sb_q.push_back(it);
        cyc(1'b0, 1'b1, a, '0, p);
    endtask

    task automatic pulse(input logic [NC-1:0] p);
        cyc(1'b0, 1'b0, '0, '0, p);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12: reset values
        check("R12 run after reset", 32'(run0), 32'h0);
        check("R12 rdata after reset", rdata0, 32'h0);
        bus_read(12'h00C, 32'h0, 32'h0, 1'b1, "R12 status after reset");
        bus_read(12'h01C, 32'h0, 32'h0, 1'b1, "R12 events after reset");

        // R1: start channels 0 and 2
        bus_write(12'h004, 32'h5);
        check("R1 run after enable", 32'(run0), 32'h5);
        bus_read(12'h00C, 32'h5, 32'h5, 1'b1, "R5 status shows running");

        // R3: zero bits and idle disable do nothing
        bus_write(12'h004, 32'h0);
        bus_write(12'h008, 32'h2);
        bus_write(12'h004, 32'h1);
        check("R3 no effect", 32'(run0), 32'h5);

        // R2: drain until period boundary
        bus_write(12'h008, 32'h1);
        check("R2 run held while draining", 32'(run0), 32'h5);
        bus_read(12'h00C, 32'h5, 32'h5, 1'b1, "R2 status held while draining");
        pulse(4'b0001);
        check("R2 run drops after boundary", 32'(run0), 32'h4);
        bus_read(12'h00C, 32'h4, 32'h4, 1'b1, "R2 status after boundary");

        // R6: events collect and clear on read
        bus_read(12'h01C, 32'h1, 32'h1, 1'b1, "R6 event collected");
        bus_read(12'h01C, 32'h0, 32'h0, 1'b1, "R6 event cleared");
        pulse(4'b0100);
        bus_read(12'h01C, 32'h4, 32'h4, 1'b1, "R6 second event");

        // R7: pulse coincident with read survives
        bus_read(12'h01C, 32'h0, 32'h0, 1'b1, "R7 coincident read", 4'b1000);
        bus_read(12'h01C, 32'h8, 32'h8, 1'b1, "R7 coincident pulse kept");

        // R4: enable cancels a drain even with a same-cycle boundary
        bus_write(12'h008, 32'h4);
        cyc(1'b1, 1'b0, 12'h004, 32'h4, 4'b0100);
        check("R4 resume wins over boundary", 32'(run0), 32'h4);
        pulse(4'b0100);
        check("R4 still running after pulse", 32'(run0), 32'h4);
        bus_read(12'h01C, 32'h4, 32'h4, 1'b1, "R6 events during resume");

        // R8/R9: channel window forwarding
        wr = 1'b1; addr = 12'h26C; wdata = 32'h1234;
        #1;
        check("R8 write strobe ch3", 32'(cwr0), 32'h8);
        check("R8 window offset", 32'(off0), 32'h0C);
        check("R9 shared layout ignores 0x0C", 32'(cwr1), 32'h0);
        @(negedge clk);
        wr = 1'b0;
        rd = 1'b1; addr = 12'h250;
        #1;
        check("R8 read strobe ch2", 32'(crd0), 32'h4);
        rd = 1'b0;
        bus_read(12'h250, 32'hA502_0010, 32'hA502_0010, 1'b1, "R8 read ch2 offset 0x10");
        bus_read(12'h22C, 32'hA501_000C, 32'h0, 1'b1, "R9 ch1 offset 0x0C by layout");
        bus_read(12'h200, 32'hA500_0000, 32'hA500_0000, 1'b1, "R8 read ch0 mode offset");

        // R10: unmapped addresses
        bus_read(12'h100, 32'h0, 32'h0, 1'b1, "R10 unmapped global");
        bus_read(12'h284, 32'h0, 32'h0, 1'b1, "R10 window past last channel");
        bus_read(12'h202, 32'h0, 32'h0, 1'b1, "R10 misaligned window offset");
        wr = 1'b1; addr = 12'h014; wdata = 32'hF;
        #1;
        check("R10 no strobe on unmapped write", 32'(cwr0), 32'h0);
        @(negedge clk);
        wr = 1'b0;
        check("R10 unmapped write leaves state", 32'(run0), 32'h4);
        check("R11 rdata holds without read", rdata0, 32'h0);

        repeat (2) @(negedge clk);
        check("R11 all reads returned", 32'(sb_q.size()), 32'h0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule